// File: doc/BRIEF.md
# Watchdog Timer with Unlock-Sequence Feed

The block is a bus-attached watchdog. Software programs a reload value, sets the enable bit, and then proves it is alive by writing a two-byte unlock pattern to a kick register. The counter is clocked through a fixed divide-by-four prescaler and counts down from the reload value. Each completed pattern copies the reload value into the counter. Setting the enable bit does not start the count. The counter starts only after the first complete unlock pattern, and once started it cannot be stopped except by system reset.

When the counter reaches zero, a sticky timeout flag is set. If the reset-enable bit is set, the block also raises a one-cycle reset request. While the watchdog is running, a broken unlock pattern also raises a reset request when reset-enable is set. A pattern is broken when the first key is followed by any other access.

The bus and the watchdog share one clock. A request is one cycle of `req_valid`. Read data is returned combinationally in the same cycle. The register is selected by `req_addr[3:2]`: 0 is mode, 1 is reload, 2 is kick, 3 is count. `req_addr[1:0]` is ignored.

Top module: `guard_timer`

## Requirements
- R1: After reset, mode reads 0, reload reads 0xFF, count reads 0xFF, kick reads 0 and `rst_req` is low.
- R2: A reload write stores `req_wdata[23:0]`, or 0xFF when that value is below 0xFF. The stored value reads back at select 1.
- R3: Mode bit 0 (enable) and bit 1 (reset-enable) are set by writing 1. Writing 0 leaves a set bit set until reset. Bit 2 is read-only.
- R4: While the watchdog is not running, the count does not change except through a reload.
- R5: A write of 0xAA (low byte) to the kick register, followed as the next bus access by a write of 0x55, reloads the count from the reload register and restarts the prescaler. If enable is set, this starts the watchdog. Idle cycles may separate the two writes.
- R6: While running, the count drops by one every fourth clock after a reload and is read at select 3. The first drop comes on the fourth clock edge after the reload edge.
- R7: When the running count steps from 1 to 0, mode bit 2 is set and the count stays at 0. If reset-enable is set, `rst_req` is high for exactly the one cycle after that edge.
- R8: After a first key, any other access breaks the pattern and returns the sequence to idle. That includes a second 0xAA, which does not restart the pattern. If the watchdog is running and reset-enable is set, `rst_req` is high in the cycle after the breaking access. Otherwise no request is raised. The breaking access itself still takes effect.
- R9: The timeout flag stays set until reset. With reset-enable clear, an expiry sets the flag and raises no request.
- R10: The kick register reads 0. A kick write of any value other than 0xAA, while no pattern is open, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | Asynchronous active-low system reset |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address; bits 3:2 select the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the current read access, else 0 |
| rst_req | output | 1 | Registered reset request |

## Verification
The hardest state to reach is a running watchdog with reset-enable set. Reaching it takes a sticky enable, an accepted unlock pattern and the correct reload timing. Only from that state can each kind of broken pattern be told apart from a harmless one. The stimulus builds this state in stages:
- It first shows that a pattern with enable clear reloads the count but leaves it frozen.
- It checks that a broken pattern before the watchdog starts leaves `rst_req` low.
- It arms the watchdog and lets one expiry happen with reset-enable clear.
- It sets reset-enable and breaks the pattern three ways: a read, a wrong second byte, and a repeated first key.

A cycle-by-cycle reference model checks the exact count and the request timing throughout.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef enum logic [1:0] {
        SEL_MODE   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_KICK   = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        KICK_IDLE = 1'b0,
        KICK_HALF = 1'b1
    } kick_state_e;

endpackage

// File: rtl/guard_regs.sv
module guard_regs #(
    parameter int CNT_W      = 24,
    parameter int RELOAD_MIN = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_mode,
    input  logic             wr_reload,
    input  logic [CNT_W-1:0] wbits,
    input  logic             expire,
    output logic             en,
    output logic             ren,
    output logic             flag,
    output logic [CNT_W-1:0] reload_val
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(RELOAD_MIN);

    typedef struct packed {
        logic             en;
        logic             ren;
        logic             flag;
        logic [CNT_W-1:0] rl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_mode) begin
            // enable bits may only be set, never cleared
            r_d.en  = r_q.en  | wbits[0];
            r_d.ren = r_q.ren | wbits[1];
        end
        if (wr_reload) begin
            r_d.rl = (wbits < MIN_V) ? MIN_V : wbits;
        end
        if (expire) begin
            r_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{en: 1'b0, ren: 1'b0, flag: 1'b0, rl: MIN_V};
        end else begin
            r_q <= r_d;
        end
    end

    assign en         = r_q.en;
    assign ren        = r_q.ren;
    assign flag       = r_q.flag;
    assign reload_val = r_q.rl;

endmodule

// File: rtl/guard_kick.sv
module guard_kick
    import guard_pkg::*;
#(
    parameter int          KEY_W = 8,
    parameter logic [7:0]  KEY_A = 8'hAA,
    parameter logic [7:0]  KEY_B = 8'h55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             kick_wr,
    input  logic [KEY_W-1:0] wbyte,
    output logic             feed_ok,
    output logic             feed_break
);
    localparam logic [KEY_W-1:0] KA = KEY_W'(KEY_A);
    localparam logic [KEY_W-1:0] KB = KEY_W'(KEY_B);

    kick_state_e st_d, st_q;

    always_comb begin
        st_d       = st_q;
        feed_ok    = 1'b0;
        feed_break = 1'b0;
        if (acc_valid) begin
            if (st_q == KICK_HALF) begin
                // any access closes an open pattern
                st_d = KICK_IDLE;
                if (kick_wr && (wbyte == KB)) begin
                    feed_ok = 1'b1;
                end else begin
                    feed_break = 1'b1;
                end
            end else if (kick_wr && (wbyte == KA)) begin
                st_d = KICK_HALF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= KICK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/guard_count.sv
module guard_count #(
    parameter int CNT_W     = 24,
    parameter int PRE_W     = 2,
    parameter int RESET_CNT = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             armed,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [PRE_W-1:0] PTOP  = '1;

    typedef struct packed {
        logic             armed;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;
    logic tick;

    always_comb begin
        c_d    = c_q;
        tick   = c_q.armed && (c_q.pre == PTOP) && !reload;
        expire = tick && (c_q.cnt == ONE);
        if (reload) begin
            c_d.cnt   = reload_val;
            c_d.pre   = '0;
            c_d.armed = c_q.armed | en;
        end else if (c_q.armed) begin
            c_d.pre = c_q.pre + 1'b1;
            if (tick && (c_q.cnt != '0)) begin
                c_d.cnt = c_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{armed: 1'b0, pre: '0, cnt: CNT_W'(RESET_CNT)};
        end else begin
            c_q <= c_d;
        end
    end

    assign count = c_q.cnt;
    assign armed = c_q.armed;

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 24,
    parameter int PRE_W      = 2,
    parameter int RELOAD_MIN = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rst_req
);
    localparam int KEY_W = 8;

    reg_sel_e         sel;
    logic             wr_mode, wr_reload, kick_wr;
    logic             en_w, ren_w, flag_w, armed_w;
    logic [CNT_W-1:0] rl_w, count_w;
    logic             feed_ok_w, feed_break_w, expire_w;
    logic             req_d, req_q;
    logic             unused_bits;

    assign sel       = reg_sel_e'(req_addr[3:2]);
    assign wr_mode   = req_valid && req_write && (sel == SEL_MODE);
    assign wr_reload = req_valid && req_write && (sel == SEL_RELOAD);
    assign kick_wr   = req_valid && req_write && (sel == SEL_KICK);
    assign unused_bits = ^{req_wdata[DATA_W-1:CNT_W], req_addr[1:0]};

    guard_regs #(.CNT_W(CNT_W), .RELOAD_MIN(RELOAD_MIN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_mode    (wr_mode),
        .wr_reload  (wr_reload),
        .wbits      (req_wdata[CNT_W-1:0]),
        .expire     (expire_w),
        .en         (en_w),
        .ren        (ren_w),
        .flag       (flag_w),
        .reload_val (rl_w)
    );

    guard_kick #(.KEY_W(KEY_W)) u_kick (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (req_valid),
        .kick_wr    (kick_wr),
        .wbyte      (req_wdata[KEY_W-1:0]),
        .feed_ok    (feed_ok_w),
        .feed_break (feed_break_w)
    );

    guard_count #(.CNT_W(CNT_W), .PRE_W(PRE_W), .RESET_CNT(RELOAD_MIN)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_w),
        .reload     (feed_ok_w),
        .reload_val (rl_w),
        .count      (count_w),
        .armed      (armed_w),
        .expire     (expire_w)
    );

    always_comb begin
        req_d = ren_w && (expire_w || (feed_break_w && armed_w));
        rsp_rdata = '0;
        if (req_valid && !req_write) begin
            unique case (sel)
                SEL_MODE:   rsp_rdata = DATA_W'({flag_w, ren_w, en_w});
                SEL_RELOAD: rsp_rdata = DATA_W'(rl_w);
                SEL_KICK:   rsp_rdata = '0;
                SEL_COUNT:  rsp_rdata = DATA_W'(count_w);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign rst_req = req_q;

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
    parameter int CNT_W      = 24,
    parameter int RELOAD_MIN = 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_req,
    input logic             en,
    input logic             ren,
    input logic             flag,
    input logic             armed,
    input logic             reload,
    input logic             feed_break,
    input logic [CNT_W-1:0] reload_val,
    input logic [CNT_W-1:0] count
);
    // R2
    reload_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_val >= CNT_W'(RELOAD_MIN));

    // R3
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);

    // R4
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !reload) |=> $stable(count));

    // R5
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == $past(reload_val)));

    // R6
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !reload) |=> (count == $past(count)) || (count == $past(count) - 1'b1));

    // R8
    break_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_break && armed && ren) |=> rst_req);

    // R7
    request_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ren);

endmodule

bind guard_timer guard_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (rst_req),
    .en         (en_w),
    .ren        (ren_w),
    .flag       (flag_w),
    .armed      (armed_w),
    .reload     (feed_ok_w),
    .feed_break (feed_break_w),
    .reload_val (rl_w),
    .count      (count_w)
);

// File: tb/test_guard_timer.sv
module test_guard_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;
    bit done = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    guard_timer i_guard_timer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rst_req(rst_req)
    );

    // behavioural reference model
    int m_en, m_ren, m_flag, m_tc, m_cnt, m_pre, m_run, m_open, m_req;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_ren = 0; m_flag = 0; m_tc = 255; m_cnt = 255;
            m_pre = 0; m_run = 0; m_open = 0; m_req = 0;
        end else begin
            int ok, brk, nreq, a, wd;
            ok = 0; brk = 0; nreq = 0;
            a = int'(req_addr) / 4;
            wd = int'(req_wdata[23:0]);
            if (req_valid) begin
                if (m_open == 1) begin
                    if (req_write && a == 2 && req_wdata[7:0] == 8'h55) ok = 1;
                    else brk = 1;
                    m_open = 0;
                end else if (req_write && a == 2 && req_wdata[7:0] == 8'hAA) begin
                    m_open = 1;
                end
            end
            if (brk == 1 && m_run == 1 && m_ren == 1) nreq = 1;
            if (ok == 1) begin
                m_cnt = m_tc; m_pre = 0;
                if (m_en == 1) m_run = 1;
            end else if (m_run == 1) begin
                if (m_pre == 3) begin
                    m_pre = 0;
                    if (m_cnt > 0) begin
                        m_cnt = m_cnt - 1;
                        if (m_cnt == 0) begin
                            m_flag = 1;
                            if (m_ren == 1) nreq = 1;
                        end
                    end
                end else begin
                    m_pre = m_pre + 1;
                end
            end
            if (req_valid && req_write && a == 0) begin
                if (req_wdata[0]) m_en = 1;
                if (req_wdata[1]) m_ren = 1;
            end
            if (req_valid && req_write && a == 1) m_tc = (wd < 255) ? 255 : wd;
            m_req = nreq;
        end
    end

    function automatic logic [31:0] model_rdata();
        int a;
        a = int'(req_addr) / 4;
        if (!(req_valid && !req_write)) return 32'h0;
        case (a)
            0: return 32'(m_flag * 4 + m_ren * 2 + m_en);
            1: return 32'(m_tc);
            3: return 32'(m_cnt);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rst_req) pulses++;
            chk({phase, " model rst_req"}, 32'(rst_req), 32'(m_req));
            chk({phase, " model rdata"}, rsp_rdata, model_rdata());
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 0; req_write = 0; req_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        v = rsp_rdata;
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic feed();
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h55);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired in phase %s actual 1 expected 0", phase);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int p0;
        idle(3); rst_n = 1;

        phase = "R1";
        rd(4'h0, v); chk("R1 mode", v, 32'h0);
        rd(4'h4, v); chk("R1 reload", v, 32'hFF);
        rd(4'hC, v); chk("R1 count", v, 32'hFF);
        rd(4'h8, v); chk("R10 kick reads zero", v, 32'h0);
        chk("R1 rst_req", 32'(rst_req), 32'h0);

        phase = "R2";
        wr(4'h4, 32'h10);        rd(4'h4, v); chk("R2 clamp low", v, 32'hFF);
        wr(4'h4, 32'h00ABCDEF);  rd(4'h4, v); chk("R2 wide value", v, 32'hABCDEF);
        wr(4'h4, 32'hFF000040);  rd(4'h4, v); chk("R2 upper bits dropped then clamp", v, 32'hFF);
        wr(4'h4, 32'h100);       rd(4'h4, v); chk("R2 store", v, 32'h100);

        phase = "R4";
        feed();
        rd(4'hC, v); chk("R5 reload without enable", v, 32'h100);
        idle(40);
        rd(4'hC, v); chk("R4 count frozen while not running", v, 32'h100);
        wr(4'h0, 32'h1);
        rd(4'h0, v); chk("R3 enable bit", v, 32'h1);
        idle(40);
        rd(4'hC, v); chk("R4 enable alone does not start", v, 32'h100);

        phase = "R10";
        wr(4'h8, 32'h37); wr(4'h8, 32'h55); idle(20);
        rd(4'hC, v); chk("R10 stray kick ignored", v, 32'h100);

        phase = "R8";
        p0 = pulses;
        wr(4'h8, 32'hAA); wr(4'h4, 32'h120); idle(3);
        rd(4'h4, v); chk("R8 breaking write executes", v, 32'h120);
        chk("R8 no request while not running", 32'(pulses - p0), 32'h0);

        phase = "R6";
        feed();
        rd(4'hC, v); chk("R5 reload on valid pattern", v, 32'h120);
        idle(100);
        rd(4'hC, v); chk("R6 count running", 32'(v < 32'h120 && v > 32'h100), 32'h1);
        wr(4'h0, 32'h0);
        rd(4'h0, v); chk("R3 enable cannot be cleared", v, 32'h1);

        phase = "R9";
        p0 = pulses;
        idle(4 * 32'h120 + 50);
        rd(4'h0, v); chk("R9 flag set on expiry", v, 32'h5);
        rd(4'hC, v); chk("R7 count held at zero", v, 32'h0);
        chk("R9 no request with reset-enable clear", 32'(pulses - p0), 32'h0);

        phase = "R7";
        wr(4'h0, 32'h2);
        rd(4'h0, v); chk("R3 reset-enable set", v, 32'h7);
        p0 = pulses;
        feed();
        idle(4 * 32'h120 + 50);
        chk("R7 single request on expiry", 32'(pulses - p0), 32'h1);
        rd(4'h0, v); chk("R9 flag stays set", v, 32'h7);

        phase = "R8";
        feed();
        p0 = pulses;
        wr(4'h8, 32'hAA); rd(4'h0, v); idle(2);
        chk("R8 read breaks pattern", 32'(pulses - p0), 32'h1);
        feed(); p0 = pulses;
        wr(4'h8, 32'hAA); wr(4'h8, 32'h12); idle(2);
        chk("R8 wrong second byte", 32'(pulses - p0), 32'h1);
        feed(); p0 = pulses;
        wr(4'h8, 32'hAA); wr(4'h8, 32'hAA); wr(4'h8, 32'h55); idle(2);
        chk("R8 repeated first key, no restart", 32'(pulses - p0), 32'h1);

        phase = "R5";
        feed(); p0 = pulses;
        for (int i = 0; i < 6; i++) begin
            idle(300);
            feed();
        end
        chk("R5 regular feeding prevents request", 32'(pulses - p0), 32'h0);

        phase = "R1";
        @(posedge clk); #1; rst_n = 0;
        idle(3); rst_n = 1;
        rd(4'h0, v); chk("R9 flag cleared by reset", v, 32'h0);
        rd(4'hC, v); chk("R1 count after reset", v, 32'hFF);
        idle(60);
        rd(4'hC, v); chk("R4 stopped after reset", v, 32'hFF);

        finish_run();
    end

endmodule